// File: doc/BRIEF.md
# Two-Phase Programmable Asynchronous USART

This block is an asynchronous serial transmitter and receiver for a host that reaches it through a small byte-wide register port. Three register slots are decoded: a data slot, a control/status slot and an interrupt-mask slot. The control slot works in two phases. After reset, or after an internal-reset command, the next write to it sets the line format. That format covers the clock factor, the character length, the parity and the number of stop bits. Every later write to the same slot is a command word. The command word gates the transmitter and the receiver, drives the DTR and RTS outputs, forces a break, and clears the sticky error flags.

The serial side counts pulses on a serial-clock enable input. Each bit lasts 1, 16 or 64 of these pulses. The receiver finds the middle of the start bit and then samples every later bit at its centre. The transmitter has a one-character holding register in front of its shift register, so the host can write the next character while the current one is still going out. An interrupt output reports receiver-ready and transmitter-ready, each gated by its own bit in the mask register.

Top module: `async_usart`

## Requirements
- R1: Only `addr_i[2:0]` is decoded. Slot 0 is data, slot 1 is control (write) and status (read), and slot 2 is the interrupt mask (read/write). A read from slots 3 to 7 returns 0xFF. A write to slots 3 to 7 changes no state.
- R2: After reset, the first write to slot 1 loads the mode byte. Every later write to slot 1 is taken as a command.
- R3: A command with bit 6 set clears all command bits, so DTR, RTS, break and both enables go low. The next write to slot 1 is then taken as a mode byte again.
- R4: Mode bits [1:0] set the clock factor: 01 gives 1, 10 gives 16 and 11 gives 64 serial-clock pulses per bit. The value 00 is handled as a factor of 1. The receiver samples the start bit at its middle and every later bit one bit-time apart.
- R5: Mode bits [3:2] set the character length to 5 + value bits. Data is sent least significant bit first. Transmitted and received characters are masked to that length.
- R6: Mode bit 4 adds a parity bit after the data bits. Mode bit 5 set selects even parity and clear selects odd parity. A received parity mismatch sets status bit 3.
- R7: Mode bits [7:6] set the stop time. The value 11 gives 2 bit-times. The value 10 gives 1.5 bit-times, which is factor + ceil(factor/2) pulses. The values 01 and 00 give 1 bit-time. When the holding register is full, the next start bit follows the stop time directly.
- R8: In the command word, bit 1 drives `dtr_o`, bit 5 drives `rts_o`, bit 2 enables the receiver, and bit 3 forces `txd_o` low one cycle after it is set. Bit 7 has no effect.
- R9: The status byte is {dsr_i, 0, framing error, overrun, parity error, transmitter empty, receiver ready, transmitter ready}, listed from bit 7 down to bit 0. After reset with `dsr_i`=1 it reads 0x85.
- R10: A write to slot 0 fills the holding register and clears transmitter ready. A character starts only while command bit 0 is set and `cts_i` is high. Transmitter empty is set only when both the holding register and the shifter are idle.
- R11: A received character sets receiver ready. A read of slot 0 with `rd_i` clears it. A stop bit sampled low sets the framing error flag.
- R12: When a character completes while receiver ready is still set and no data read is taking place, the overrun flag is set and the new character replaces the old one.
- R13: The mask register resets to 0x0F. `irq_o` is high when receiver ready is set and mask bit 0 is 0, or when transmitter ready is set and mask bit 1 is 0.
- R14: A command with bit 4 set clears the parity, overrun and framing flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address; only bits [2:0] are decoded |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; has side effects only on slot 0 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed slot |
| sclk_en_i | input | 1 | Serial clock enable, one pulse per factor tick |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line, idle high |
| cts_i | input | 1 | Clear to send; high allows a character to start |
| dsr_i | input | 1 | Data set ready, reported in status bit 7 |
| dtr_o | output | 1 | Data terminal ready, from command bit 1 |
| rts_o | output | 1 | Request to send, from command bit 5 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check a set of rules on every cycle. A control write in the mode phase always moves the port to the command phase, and an internal-reset command always moves it back. Break holds the line low. An idle transmitter keeps the line high. A data read with no arriving character leaves receiver ready low. A character that arrives over an unread one always raises overrun. The bench scenarios are needed for what happens along the line and over time. These cover the bit widths at each clock factor, the spacing between back-to-back frames for each stop setting, the masking of 5-bit characters, the parity and framing errors from frames the bench builds itself, the gating by transmit enable and CTS, the address aliasing, and the interrupt masking.

// File: rtl/usart_pkg.sv
package usart_pkg;

  localparam int unsigned FAC_MAX = 64;
  localparam int unsigned CNT_W   = $clog2(2 * FAC_MAX + 1);

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] fac;
  } mode_t;

  typedef struct packed {
    logic hunt;
    logic ireset;
    logic rts;
    logic err_clr;
    logic brk;
    logic rx_en;
    logic dtr;
    logic tx_en;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } ser_st_e;

  function automatic logic [CNT_W-1:0] fac_ticks(input logic [1:0] fac);
    case (fac)
      2'b10:   return CNT_W'(16);
      2'b11:   return CNT_W'(64);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] stop_ticks(input mode_t m);
    logic [CNT_W-1:0] f;
    f = fac_ticks(m.fac);
    case (m.stop)
      2'b10:   return f + ((f + CNT_W'(1)) >> 1);
      2'b11:   return f << 1;
      default: return f;
    endcase
  endfunction

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [7:0] char_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

endpackage

// File: rtl/usart_ctrl.sv
module usart_ctrl
  import usart_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output mode_t             mode_o,
  output cmd_t              cmd_o,
  output logic              mode_phase_o,
  output logic              ctl_wr_o,
  output logic              data_rd_o,
  output logic              tx_load_o,
  output logic [7:0]        tx_data_o,
  input  logic              hold_empty_i,
  input  logic              tx_empty_i,
  input  logic              rx_done_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_pe_i,
  input  logic              rx_fe_i,
  input  logic              dsr_i,
  output logic              rx_rdy_o,
  output logic              oe_o,
  output logic              irq_o
);

  localparam logic [2:0] SLOT_DATA = 3'd0;
  localparam logic [2:0] SLOT_CTL  = 3'd1;
  localparam logic [2:0] SLOT_MASK = 3'd2;

  logic [2:0] slot;
  logic       data_wr, mask_wr;
  logic       mode_phase_q;
  mode_t      mode_q;
  cmd_t       cmd_q;
  logic [7:0] mask_q, rbuf_q;
  logic       rx_rdy_q, pe_q, oe_q, fe_q;
  logic       err_clr;
  logic [7:0] status;

  assign slot      = addr_i[2:0];
  assign data_wr   = wr_i && (slot == SLOT_DATA);
  assign ctl_wr_o  = wr_i && (slot == SLOT_CTL);
  assign mask_wr   = wr_i && (slot == SLOT_MASK);
  assign data_rd_o = rd_i && (slot == SLOT_DATA);
  assign err_clr   = ctl_wr_o && !mode_phase_q && wdata_i[4] && !wdata_i[6];

  assign tx_load_o = data_wr;
  assign tx_data_o = wdata_i & char_mask(mode_q.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_phase_q <= 1'b1;
      mode_q       <= '0;
      cmd_q        <= '0;
      mask_q       <= 8'h0F;
    end else begin
      if (ctl_wr_o) begin
        if (mode_phase_q) begin
          mode_q       <= mode_t'(wdata_i);
          mode_phase_q <= 1'b0;
        end else if (wdata_i[6]) begin
          cmd_q        <= '0;
          mode_phase_q <= 1'b1;
        end else begin
          cmd_q <= cmd_t'(wdata_i);
        end
      end
      if (mask_wr) mask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q   <= '0;
      rx_rdy_q <= 1'b0;
      pe_q     <= 1'b0;
      oe_q     <= 1'b0;
      fe_q     <= 1'b0;
    end else begin
      if (err_clr) begin
        pe_q <= 1'b0;
        oe_q <= 1'b0;
        fe_q <= 1'b0;
      end
      if (rx_done_i) begin
        rbuf_q   <= rx_data_i & char_mask(mode_q.len);
        rx_rdy_q <= 1'b1;
        if (rx_rdy_q && !data_rd_o) oe_q <= 1'b1;
        if (rx_pe_i) pe_q <= 1'b1;
        if (rx_fe_i) fe_q <= 1'b1;
      end else if (data_rd_o) begin
        rx_rdy_q <= 1'b0;
      end
    end
  end

  assign status = {dsr_i, 1'b0, fe_q, oe_q, pe_q, tx_empty_i, rx_rdy_q, hold_empty_i};

  always_comb begin
    case (slot)
      SLOT_DATA: rdata_o = rbuf_q;
      SLOT_CTL:  rdata_o = status;
      SLOT_MASK: rdata_o = mask_q;
      default:   rdata_o = 8'hFF;
    endcase
  end

  assign irq_o        = (!mask_q[0] && rx_rdy_q) || (!mask_q[1] && hold_empty_i);
  assign mode_o       = mode_q;
  assign cmd_o        = cmd_q;
  assign mode_phase_o = mode_phase_q;
  assign rx_rdy_o     = rx_rdy_q;
  assign oe_o         = oe_q;

endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  mode_t      mode_i,
  input  logic       tx_en_i,
  input  logic       cts_i,
  input  logic       brk_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  output logic       hold_empty_o,
  output logic       tx_empty_o,
  output logic       txd_o
);

  ser_st_e          st_q;
  logic [7:0]       hold_q, sh_q;
  logic             full_q, acc_q, txd_q;
  logic [2:0]       idx_q;
  logic [CNT_W-1:0] cnt_q, f, stp;
  logic [3:0]       bits;
  logic             bit_end, stop_end, can_go, line;

  always_comb begin
    f        = fac_ticks(mode_i.fac);
    stp      = stop_ticks(mode_i);
    bits     = char_bits(mode_i.len);
    bit_end  = (cnt_q == f - CNT_W'(1));
    stop_end = (cnt_q == stp - CNT_W'(1));
    can_go   = full_q && tx_en_i && cts_i;
    case (st_q)
      S_START: line = 1'b0;
      S_DATA:  line = sh_q[0];
      S_PAR:   line = mode_i.even ? acc_q : ~acc_q;
      default: line = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      acc_q  <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      txd_q  <= 1'b1;
    end else begin
      if (tick_i) begin
        case (st_q)
          S_IDLE: begin
            if (can_go) begin
              sh_q   <= hold_q;
              full_q <= 1'b0;
              acc_q  <= 1'b0;
              cnt_q  <= '0;
              st_q   <= S_START;
            end
          end
          S_START: begin
            if (bit_end) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= S_DATA;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              acc_q <= acc_q ^ sh_q[0];
              sh_q  <= sh_q >> 1;
              idx_q <= idx_q + 3'd1;
              if ({1'b0, idx_q} == bits - 4'd1) st_q <= mode_i.par_en ? S_PAR : S_STOP;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_PAR: begin
            if (bit_end) begin
              cnt_q <= '0;
              st_q  <= S_STOP;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_STOP: begin
            if (stop_end) begin
              cnt_q <= '0;
              if (can_go) begin
                sh_q   <= hold_q;
                full_q <= 1'b0;
                acc_q  <= 1'b0;
                st_q   <= S_START;
              end else st_q <= S_IDLE;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          default: st_q <= S_IDLE;
        endcase
      end
      if (load_i) begin
        hold_q <= load_data_i;
        full_q <= 1'b1;
      end
      txd_q <= brk_i ? 1'b0 : line;
    end
  end

  assign hold_empty_o = !full_q;
  assign tx_empty_o   = !full_q && (st_q == S_IDLE);
  assign txd_o        = txd_q;

endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  mode_t      mode_i,
  input  logic       rx_en_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       pe_o,
  output logic       fe_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd;
  ser_st_e                st_q;
  logic [7:0]             sh_q, data_q;
  logic [2:0]             idx_q;
  logic [CNT_W-1:0]       cnt_q, f;
  logic [3:0]             bits;
  logic                   acc_q, pe_q, fe_q, done_q, bit_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
  end
  assign rxd = sync_q[SYNC_STAGES-1];

  always_comb begin
    f       = fac_ticks(mode_i.fac);
    bits    = char_bits(mode_i.len);
    bit_end = (cnt_q == f - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      sh_q   <= '0;
      data_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        case (st_q)
          S_IDLE: begin
            if (rx_en_i && !rxd) begin
              idx_q <= '0;
              acc_q <= 1'b0;
              pe_q  <= 1'b0;
              if (f == CNT_W'(1)) begin
                cnt_q <= '0;
                st_q  <= S_DATA;
              end else begin
                cnt_q <= CNT_W'(1);
                st_q  <= S_START;
              end
            end
          end
          S_START: begin
            if (cnt_q == (f >> 1)) begin
              cnt_q <= '0;
              st_q  <= rxd ? S_IDLE : S_DATA;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= {rxd, sh_q[7:1]};
              acc_q <= acc_q ^ rxd;
              idx_q <= idx_q + 3'd1;
              if ({1'b0, idx_q} == bits - 4'd1) st_q <= mode_i.par_en ? S_PAR : S_STOP;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_PAR: begin
            if (bit_end) begin
              cnt_q <= '0;
              pe_q  <= mode_i.even ? (rxd ^ acc_q) : ~(rxd ^ acc_q);
              st_q  <= S_STOP;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_STOP: begin
            if (bit_end) begin
              cnt_q  <= '0;
              data_q <= sh_q >> (2'd3 - mode_i.len);
              fe_q   <= !rxd;
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign pe_o   = pe_q;
  assign fe_o   = fe_q;

endmodule

// File: rtl/async_usart.sv
module async_usart
  import usart_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              sclk_en_i,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              cts_i,
  input  logic              dsr_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              irq_o
);

  mode_t      mode;
  cmd_t       cmd;
  logic       mode_phase, ctl_wr, data_rd, tx_load;
  logic [7:0] tx_data, rx_data;
  logic       hold_empty, tx_empty, rx_done, rx_pe, rx_fe, rx_rdy, oe;
  logic       brk;

  usart_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .mode_o(mode), .cmd_o(cmd), .mode_phase_o(mode_phase),
    .ctl_wr_o(ctl_wr), .data_rd_o(data_rd),
    .tx_load_o(tx_load), .tx_data_o(tx_data),
    .hold_empty_i(hold_empty), .tx_empty_i(tx_empty),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_pe_i(rx_pe), .rx_fe_i(rx_fe),
    .dsr_i, .rx_rdy_o(rx_rdy), .oe_o(oe), .irq_o
  );

  assign brk = cmd.brk;

  usart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(sclk_en_i), .mode_i(mode),
    .tx_en_i(cmd.tx_en), .cts_i, .brk_i(brk),
    .load_i(tx_load), .load_data_i(tx_data),
    .hold_empty_o(hold_empty), .tx_empty_o(tx_empty), .txd_o
  );

  usart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .tick_i(sclk_en_i), .mode_i(mode),
    .rx_en_i(cmd.rx_en), .rxd_i,
    .done_o(rx_done), .data_o(rx_data), .pe_o(rx_pe), .fe_o(rx_fe)
  );

  assign dtr_o = cmd.dtr;
  assign rts_o = cmd.rts;

endmodule

// File: rtl/async_usart_chk.sv
module async_usart_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_wr,
  input logic       mode_phase,
  input logic [7:0] wdata_i,
  input logic       brk,
  input logic       txd_o,
  input logic       tx_empty,
  input logic       data_rd,
  input logic       rx_done,
  input logic       rx_rdy,
  input logic       oe
);

  p_mode_to_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && mode_phase) |=> !mode_phase);

  p_ireset_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !mode_phase && wdata_i[6]) |=> mode_phase);

  p_break_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk |=> !txd_o);

  p_idle_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty && !brk && !$past(brk) && $past(tx_empty)) |-> txd_o);

  p_read_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !rx_done) |=> !rx_rdy);

  p_overrun_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_rdy && !data_rd) |=> oe);

endmodule

bind async_usart async_usart_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr(ctl_wr), .mode_phase(mode_phase),
  .wdata_i(wdata_i), .brk(brk), .txd_o(txd_o), .tx_empty(tx_empty),
  .data_rd(data_rd), .rx_done(rx_done), .rx_rdy(rx_rdy), .oe(oe)
);

// File: tb/async_usart_bench.sv
module async_usart_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       wr = 1'b0, rd = 1'b0;
  logic       sclk_en = 1'b1;
  logic       loop = 1'b1, rxd_drv = 1'b1;
  logic       cts = 1'b1, dsr = 1'b1;
  logic       txd, dtr, rts, irq;
  logic       rxd;
  int         vectors = 0, fails = 0;

  always #5 clk = ~clk;
  assign rxd = loop ? txd : rxd_drv;

  async_usart u_async_usart (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_en_i(sclk_en), .rxd_i(rxd),
    .txd_o(txd), .cts_i(cts), .dsr_i(dsr), .dtr_o(dtr), .rts_o(rts), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); addr = 8'd0; rd = 1'b1; #1; v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_rx(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      peek(8'd1, s);
      if (s[1]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_tx_idle();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      peek(8'd1, s);
      if (s[2]) break;
    end
  endtask

  task automatic cfg(input logic [7:0] mode, input logic [7:0] cmd);
    wr_reg(8'd1, 8'h40);
    wr_reg(8'd1, mode);
    wr_reg(8'd1, cmd);
  endtask

  // bench-built frame on rxd, factor 1
  task automatic ser_send(input logic [7:0] d, input int nbits, input bit par_en,
                          input logic par_bit, input logic stop_bit);
    loop = 1'b0;
    @(negedge clk); rxd_drv = 1'b0;
    for (int i = 0; i < nbits; i++) begin @(negedge clk); rxd_drv = d[i]; end
    if (par_en) begin @(negedge clk); rxd_drv = par_bit; end
    @(negedge clk); rxd_drv = stop_bit;
    @(negedge clk); rxd_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(8'd1, v); chk("R9 status after reset", v, 8'h85);
    peek(8'd2, v); chk("R13 mask reset", v, 8'h0F);
    chk("R13 irq idle", irq, 1'b0);
    chk("R8 dtr/rts reset", {dtr, rts}, 2'b00);
    chk("R10 txd idle", txd, 1'b1);
  endtask

  task automatic t_mode_cmd();
    wr_reg(8'd1, 8'h4D);
    chk("R2 mode write not a command", {dtr, rts}, 2'b00);
    wr_reg(8'd1, 8'h27);
    chk("R2 R8 command drives dtr/rts", {dtr, rts}, 2'b11);
    wr_reg(8'd1, 8'hA7);
    chk("R8 hunt bit no effect", {dtr, rts, txd}, 3'b111);
  endtask

  task automatic t_loop8();
    logic [7:0] v; bit ok;
    wr_reg(8'd0, 8'hA5);
    wait_rx(ok); chk("R11 rx ready set", ok, 1'b1);
    rd_data(v); chk("R4 R5 loopback data", v, 8'hA5);
    peek(8'd1, v); chk("R11 read clears rx ready", v[1], 1'b0);
    chk("R12 no overrun", v[4], 1'b0);
  endtask

  task automatic t_ireset();
    wr_reg(8'd1, 8'h40);
    chk("R3 internal reset clears command", {dtr, rts}, 2'b00);
    wr_reg(8'd1, 8'h4D);
    @(negedge clk);
    chk("R3 next write is mode, no break", {txd, dtr}, 2'b10);
    wr_reg(8'd1, 8'h27);
    chk("R3 command phase again", {dtr, rts}, 2'b11);
  endtask

  task automatic t_len5();
    logic [7:0] v; bit ok;
    cfg(8'h41, 8'h27);
    wr_reg(8'd0, 8'hFF);
    wait_rx(ok);
    rd_data(v); chk("R5 5-bit character masked", v, 8'h1F);
    wr_reg(8'd0, 8'hEA);
    wait_rx(ok);
    rd_data(v); chk("R5 5-bit pattern", v, 8'h0A);
  endtask

  task automatic t_parity();
    logic [7:0] v; bit ok;
    cfg(8'h7D, 8'h27);
    wr_reg(8'd0, 8'h03);
    wait_rx(ok); rd_data(v);
    chk("R6 even parity loopback data", v, 8'h03);
    peek(8'd1, v); chk("R6 no parity error", v[3], 1'b0);
    cfg(8'h5D, 8'h27);
    wr_reg(8'd0, 8'h07);
    wait_rx(ok); rd_data(v);
    peek(8'd1, v); chk("R6 odd parity loopback clean", v[3], 1'b0);
    cfg(8'h7D, 8'h27);
    ser_send(8'h03, 8, 1'b1, 1'b1, 1'b1);
    peek(8'd1, v); chk("R6 parity error flagged", v[3], 1'b1);
    rd_data(v);
    wr_reg(8'd1, 8'h37);
    peek(8'd1, v); chk("R14 error clear", v[5:3], 3'b000);
    loop = 1'b1;
  endtask

  task automatic t_framing();
    logic [7:0] v;
    cfg(8'h4D, 8'h27);
    ser_send(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    peek(8'd1, v); chk("R11 framing error flagged", v[5], 1'b1);
    rd_data(v); chk("R11 framed data still delivered", v, 8'h5A);
    wr_reg(8'd1, 8'h37);
    peek(8'd1, v); chk("R14 framing cleared", v[5], 1'b0);
    loop = 1'b1;
  endtask

  task automatic t_overrun();
    logic [7:0] v; bit ok;
    cfg(8'h4D, 8'h27);
    ser_send(8'h11, 8, 1'b0, 1'b0, 1'b1);
    ser_send(8'h22, 8, 1'b0, 1'b0, 1'b1);
    peek(8'd1, v); chk("R12 overrun flagged", v[4], 1'b1);
    rd_data(v); chk("R12 newest character kept", v, 8'h22);
    wr_reg(8'd1, 8'h37);
    loop = 1'b1;
  endtask

  task automatic t_x16();
    logic [7:0] v; bit ok;
    cfg(8'h4E, 8'h27);
    fork
      wr_reg(8'd0, 8'h01);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (15) @(negedge clk);
        chk("R4 x16 start still low", txd, 1'b0);
        @(negedge clk);
        chk("R4 x16 bit0 after 16", txd, 1'b1);
      end
    join
    wait_rx(ok); rd_data(v);
    chk("R4 x16 loopback", v, 8'h01);
  endtask

  task automatic frame_gap(input logic [7:0] mode, input int exp, input string tag);
    int n;
    cfg(mode, 8'h27);
    cts = 1'b0;
    wr_reg(8'd0, 8'hFF);
    n = 0;
    fork
      begin
        cts = 1'b1;
        wait_tx_hold();
        wr_reg(8'd0, 8'hFF);
      end
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin @(negedge clk); n++; end
        while (txd === 1'b1 && n < 2000) begin @(negedge clk); n++; end
      end
    join
    chk(tag, n, exp);
    wait_tx_idle();
    repeat (200) @(negedge clk);
    wr_reg(8'd1, 8'h37);
    begin logic [7:0] v; rd_data(v); rd_data(v); end
    wr_reg(8'd1, 8'h37);
  endtask

  task automatic wait_tx_hold();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      peek(8'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic t_gate();
    logic [7:0] v; bit ok;
    cfg(8'h4D, 8'h26);
    wr_reg(8'd0, 8'h55);
    repeat (20) begin @(negedge clk); if (txd !== 1'b1) break; end
    chk("R10 tx enable gates start", txd, 1'b1);
    peek(8'd1, v); chk("R10 holding full status", v[2:0], 3'b000);
    wr_reg(8'd1, 8'h27);
    wait_rx(ok); rd_data(v); chk("R10 released char", v, 8'h55);
    cts = 1'b0;
    wr_reg(8'd0, 8'h66);
    repeat (20) @(negedge clk);
    chk("R10 cts gates start", txd, 1'b1);
    cts = 1'b1;
    wait_rx(ok); rd_data(v); chk("R10 cts released char", v, 8'h66);
  endtask

  task automatic t_break();
    wr_reg(8'd1, 8'h2F);
    @(negedge clk);
    chk("R8 break holds line low", txd, 1'b0);
    wr_reg(8'd1, 8'h23);
    @(negedge clk);
    chk("R8 break released", txd, 1'b1);
    wr_reg(8'd1, 8'h27);
  endtask

  task automatic t_irq();
    logic [7:0] v; bit ok;
    wr_reg(8'd2, 8'h0E);
    chk("R13 rx irq idle", irq, 1'b0);
    wr_reg(8'd0, 8'h3C);
    wait_rx(ok);
    @(negedge clk); chk("R13 rx irq asserted", irq, 1'b1);
    rd_data(v);
    @(negedge clk); chk("R13 rx irq cleared by read", irq, 1'b0);
    wr_reg(8'd2, 8'h0D);
    @(negedge clk); chk("R13 tx irq on empty holding", irq, 1'b1);
    wr_reg(8'd2, 8'h0F);
  endtask

  task automatic t_addr();
    logic [7:0] v, s;
    peek(8'd1, s);
    peek(8'h09, v); chk("R1 alias of status slot", v, s);
    wr_reg(8'h0A, 8'h0B);
    peek(8'd2, v); chk("R1 alias write to mask", v, 8'h0B);
    peek(8'h03, v); chk("R1 unused slot reads FF", v, 8'hFF);
    peek(8'h07, v); chk("R1 slot 7 reads FF", v, 8'hFF);
    wr_reg(8'h05, 8'h00);
    peek(8'd2, v); chk("R1 unused write ignored (mask)", v, 8'h0B);
    chk("R1 unused write ignored (dtr/rts)", {dtr, rts}, 2'b11);
    wr_reg(8'd2, 8'h0F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_cmd();
    t_loop8();
    t_ireset();
    t_break();
    t_len5();
    t_parity();
    t_framing();
    t_overrun();
    t_x16();
    frame_gap(8'h4D, 10, "R7 one stop x1 gap");
    frame_gap(8'hCD, 11, "R7 two stop x1 gap");
    frame_gap(8'h8E, 168, "R7 one-and-half stop x16 gap");
    cfg(8'h4D, 8'h27);
    t_gate();
    t_irq();
    t_addr();
    finish_run();
  end

endmodule